// File: doc/BRIEF.md
# CAN Controller Mode and Status Register

This block is the byte-wide control and status register that sits between a CPU bus and a CAN protocol engine. Software reads and writes it through a simple strobe-and-data port. The protocol engine feeds it a pulse when a valid frame has arrived, a level while a frame is being received, a level once it is synchronized to the bus, and an acknowledge for initialization requests. The register drives the mode controls back out to the engine. It also drives a clock-enable for the bus-interface logic, which drops in wait mode when software has asked for that.

Per-bit access depends on whether the controller is in initialization mode. Initialization mode is in effect while the init-request bit is 1 and the engine's acknowledge input is 1. In that mode the status bits, the timer enable and the clock-stop-in-wait bit are held at their reset values. The wake-up enable and the sleep request keep whatever they held. Only the init-request bit accepts CPU writes. The other writable bits accept writes again only once init-request and the acknowledge are both back at 0.

The received-frame flag is sticky. Hardware sets it and software clears it by writing a 1 to it. Reads have no side effects. Every state change happens on one rising clock edge, and the block has a synchronous active-high reset.

Top module: `canctl_reg`

## Requirements
- R1: After reset the read value is 0x01 (only init-request set), the control outputs other than init-request are 0, and the clock-enable output is 1.
- R2: The read value places, from bit 7 down to bit 0: received-frame flag, receiver-active, clock-stop-in-wait, synchronized, timer-enable, wake-up-enable, sleep-request, init-request.
- R3: A one-cycle receive pulse sets the received-frame flag (bit 7) at the next clock edge. The flag then stays 1 until it is cleared.
- R4: A CPU write with bit 7 = 1 clears the flag. A write with bit 7 = 0 leaves it unchanged, and no write can set it.
- R5: When a receive pulse and a clearing write land in the same cycle, the flag ends up 1.
- R6: While the loopback input is 1, a receive pulse does not set the flag.
- R7: Bits 6 (receiver-active) and 4 (synchronized) show the receiver-busy and bus-synchronized inputs one clock later. CPU writes to these bits have no effect.
- R8: While init-request and the acknowledge input are both 1, the next edge drives bits 7 to 3 to 0. Wake-up-enable and sleep-request keep their values.
- R9: A write to bits 5, 3, 2 and 1 takes effect only when init-request is 0 and the acknowledge is 0. A write to bit 0 (init-request) always takes effect.
- R10: The clock-enable output goes to 0 one clock after clock-stop-in-wait and the wait-mode input are both 1. It is 1 one clock after any other combination.
- R11: The control outputs equal the matching register bits at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr_en | input | 1 | CPU write strobe, one cycle per write |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Current register contents |
| hw_rx_done | input | 1 | Pulse: valid frame received |
| hw_rx_busy | input | 1 | Level: receiver is taking in a frame |
| hw_bus_sync | input | 1 | Level: engine synchronized to the bus |
| hw_init_ack | input | 1 | Engine acknowledges initialization request |
| hw_loopback | input | 1 | Loopback mode active; receive pulses are ignored |
| wait_mode | input | 1 | System wait mode |
| ctl_clk_stop_wait | output | 1 | Clock-stop-in-wait control bit |
| ctl_timer_en | output | 1 | Timer enable control bit |
| ctl_wake_en | output | 1 | Wake-up enable control bit |
| ctl_sleep_req | output | 1 | Sleep request control bit |
| ctl_init_req | output | 1 | Init request control bit |
| bif_clk_en | output | 1 | Clock enable for the bus-interface logic |

## Verification
The bench builds the block with its default reset value of 0x01, so it comes out of reset with init-request set. That lets it walk the whole entry and exit of initialization mode: the half-open windows where only one of request and acknowledge is 1, the forced bits, and the frozen-but-kept wake and sleep bits. Directed sequences cover a receive pulse that collides with a clearing write, receive pulses under loopback, and the wait-mode gate. A pseudo-random phase then toggles the acknowledge, the status levels and CPU writes together, so that the rare mixes of these inputs also get compared against the model.

// File: rtl/canctl_pkg.sv
package canctl_pkg;
  localparam int REG_W  = 8;
  localparam int B_RXF  = 7;
  localparam int B_BUSY = 6;
  localparam int B_CSW  = 5;
  localparam int B_SYNC = 4;
  localparam int B_TIM  = 3;
  localparam int B_WAKE = 2;
  localparam int B_SLP  = 1;
  localparam int B_INIT = 0;

  // Packed MSB first, so a cast gives the read layout directly.
  typedef struct packed {
    logic rx_frame;
    logic rx_busy;
    logic clk_stop_wait;
    logic bus_sync;
    logic timer_en;
    logic wake_en;
    logic sleep_req;
    logic init_req;
  } ctl_view_t;
endpackage

// File: rtl/canctl_sticky_flag.sv
module canctl_sticky_flag #(
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic force_rst,
  input  logic set_req,
  input  logic clr_req,
  output logic flag_q
);
  // Forcing dominates; a set outranks a clear arriving in the same cycle.
  always_ff @(posedge clk) begin
    if (rst || force_rst)
      flag_q <= RST_VAL;
    else if (set_req)
      flag_q <= 1'b1;
    else if (clr_req)
      flag_q <= 1'b0;
  end
endmodule

// File: rtl/canctl_status_sample.sv
module canctl_status_sample #(
  parameter int           W       = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         force_rst,
  input  logic [W-1:0] hw_in,
  output logic [W-1:0] stat_q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst || force_rst)
        stat_q[i] <= RST_VAL[i];
      else
        stat_q[i] <= hw_in[i];
    end
  end
endmodule

// File: rtl/canctl_ctrl_bits.sv
module canctl_ctrl_bits #(
  parameter int           W           = 5,
  parameter logic [W-1:0] RST_VAL     = '0,
  parameter logic [W-1:0] FREEZE_MASK = '0,
  parameter logic [W-1:0] GATED_MASK  = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         freeze,
  input  logic         wr_open,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] ctl_q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (FREEZE_MASK[i]) begin : g_frz
      always_ff @(posedge clk) begin
        if (rst || freeze)
          ctl_q[i] <= RST_VAL[i];
        else if (wr_en && (wr_open || !GATED_MASK[i]))
          ctl_q[i] <= wdata[i];
      end
    end else begin : g_hold
      always_ff @(posedge clk) begin
        if (rst)
          ctl_q[i] <= RST_VAL[i];
        else if (wr_en && (wr_open || !GATED_MASK[i]))
          ctl_q[i] <= wdata[i];
      end
    end
  end
endmodule

// File: rtl/canctl_clk_gate.sv
module canctl_clk_gate (
  input  logic clk,
  input  logic rst,
  input  logic stop_in_wait,
  input  logic wait_mode,
  output logic clk_en_q
);
  always_ff @(posedge clk) begin
    if (rst)
      clk_en_q <= 1'b1;
    else
      clk_en_q <= !(stop_in_wait && wait_mode);
  end
endmodule

// File: rtl/canctl_reg.sv
module canctl_reg
  import canctl_pkg::*;
#(
  parameter logic [REG_W-1:0] RST_VALUE = 8'h01
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cpu_wr_en,
  input  logic [REG_W-1:0] cpu_wdata,
  output logic [REG_W-1:0] cpu_rdata,
  input  logic             hw_rx_done,
  input  logic             hw_rx_busy,
  input  logic             hw_bus_sync,
  input  logic             hw_init_ack,
  input  logic             hw_loopback,
  input  logic             wait_mode,
  output logic             ctl_clk_stop_wait,
  output logic             ctl_timer_en,
  output logic             ctl_wake_en,
  output logic             ctl_sleep_req,
  output logic             ctl_init_req,
  output logic             bif_clk_en
);
  // Control bank order: {csw, timer, wake, sleep, init}
  localparam int         CTL_W      = 5;
  localparam logic [4:0] CTL_RST    = {RST_VALUE[B_CSW], RST_VALUE[B_TIM],
                                       RST_VALUE[B_WAKE], RST_VALUE[B_SLP],
                                       RST_VALUE[B_INIT]};
  localparam logic [4:0] CTL_FREEZE = 5'b11000;
  localparam logic [4:0] CTL_GATED  = 5'b11110;
  localparam logic [1:0] STAT_RST   = {RST_VALUE[B_BUSY], RST_VALUE[B_SYNC]};

  logic             init_active;
  logic             wr_open;
  logic [CTL_W-1:0] ctl_q;
  logic [CTL_W-1:0] ctl_wd;
  logic [1:0]       stat_q;
  logic             rx_flag_q;
  ctl_view_t        view;
  logic             unused_ro_wdata;

  assign init_active     = ctl_q[0] & hw_init_ack;
  assign wr_open         = ~ctl_q[0] & ~hw_init_ack;
  assign ctl_wd          = {cpu_wdata[B_CSW], cpu_wdata[B_TIM], cpu_wdata[B_WAKE],
                            cpu_wdata[B_SLP], cpu_wdata[B_INIT]};
  assign unused_ro_wdata = cpu_wdata[B_BUSY] ^ cpu_wdata[B_SYNC];

  canctl_sticky_flag #(.RST_VAL(RST_VALUE[B_RXF])) u_rxf (
    .clk       (clk),
    .rst       (rst),
    .force_rst (init_active),
    .set_req   (hw_rx_done & ~hw_loopback),
    .clr_req   (cpu_wr_en & cpu_wdata[B_RXF]),
    .flag_q    (rx_flag_q)
  );

  canctl_status_sample #(.W(2), .RST_VAL(STAT_RST)) u_stat (
    .clk       (clk),
    .rst       (rst),
    .force_rst (init_active),
    .hw_in     ({hw_rx_busy, hw_bus_sync}),
    .stat_q    (stat_q)
  );

  canctl_ctrl_bits #(
    .W           (CTL_W),
    .RST_VAL     (CTL_RST),
    .FREEZE_MASK (CTL_FREEZE),
    .GATED_MASK  (CTL_GATED)
  ) u_ctl (
    .clk     (clk),
    .rst     (rst),
    .freeze  (init_active),
    .wr_open (wr_open),
    .wr_en   (cpu_wr_en),
    .wdata   (ctl_wd),
    .ctl_q   (ctl_q)
  );

  canctl_clk_gate u_cg (
    .clk          (clk),
    .rst          (rst),
    .stop_in_wait (ctl_q[4]),
    .wait_mode    (wait_mode),
    .clk_en_q     (bif_clk_en)
  );

  always_comb begin
    view.rx_frame      = rx_flag_q;
    view.rx_busy       = stat_q[1];
    view.clk_stop_wait = ctl_q[4];
    view.bus_sync      = stat_q[0];
    view.timer_en      = ctl_q[3];
    view.wake_en       = ctl_q[2];
    view.sleep_req     = ctl_q[1];
    view.init_req      = ctl_q[0];
  end

  assign cpu_rdata         = REG_W'(view);
  assign ctl_clk_stop_wait = ctl_q[4];
  assign ctl_timer_en      = ctl_q[3];
  assign ctl_wake_en       = ctl_q[2];
  assign ctl_sleep_req     = ctl_q[1];
  assign ctl_init_req      = ctl_q[0];
endmodule

// File: rtl/canctl_reg_chk.sv
module canctl_reg_chk (
  input logic       clk,
  input logic       rst,
  input logic       cpu_wr_en,
  input logic [7:0] cpu_wdata,
  input logic [7:0] cpu_rdata,
  input logic       hw_rx_done,
  input logic       hw_init_ack,
  input logic       hw_loopback,
  input logic       wait_mode,
  input logic       ctl_clk_stop_wait,
  input logic       ctl_wake_en,
  input logic       ctl_sleep_req,
  input logic       ctl_init_req,
  input logic       bif_clk_en
);
  logic in_init;
  logic open_wr;
  assign in_init = ctl_init_req && hw_init_ack;
  assign open_wr = !ctl_init_req && !hw_init_ack;

  AST_RX_STICKY: assert property (@(posedge clk) disable iff (rst)
    (cpu_rdata[7] && !(cpu_wr_en && cpu_wdata[7]) && !in_init) |=> cpu_rdata[7]); // R3
  AST_RX_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (hw_rx_done && !hw_loopback && !in_init) |=> cpu_rdata[7]); // R5
  AST_LOOPBACK_BLOCK: assert property (@(posedge clk) disable iff (rst)
    (hw_loopback && !cpu_rdata[7]) |=> !cpu_rdata[7]); // R6
  AST_INIT_FORCE: assert property (@(posedge clk) disable iff (rst)
    in_init |=> (cpu_rdata[7:3] == 5'b0)); // R8
  AST_LOCKED_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(cpu_wr_en && open_wr) |=> $stable({ctl_wake_en, ctl_sleep_req})); // R9
  AST_CLK_GATE_OFF: assert property (@(posedge clk) disable iff (rst)
    (ctl_clk_stop_wait && wait_mode) |=> !bif_clk_en); // R10
  AST_CLK_GATE_ON: assert property (@(posedge clk) disable iff (rst)
    !(ctl_clk_stop_wait && wait_mode) |=> bif_clk_en); // R10
endmodule

bind canctl_reg canctl_reg_chk u_chk (
  .clk               (clk),
  .rst               (rst),
  .cpu_wr_en         (cpu_wr_en),
  .cpu_wdata         (cpu_wdata),
  .cpu_rdata         (cpu_rdata),
  .hw_rx_done        (hw_rx_done),
  .hw_init_ack       (hw_init_ack),
  .hw_loopback       (hw_loopback),
  .wait_mode         (wait_mode),
  .ctl_clk_stop_wait (ctl_clk_stop_wait),
  .ctl_wake_en       (ctl_wake_en),
  .ctl_sleep_req     (ctl_sleep_req),
  .ctl_init_req      (ctl_init_req),
  .bif_clk_en        (bif_clk_en)
);

// File: tb/sim_canctl_reg.sv
`timescale 1ns/1ps
module sim_canctl_reg;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cpu_wr_en = 1'b0;
  logic [7:0] cpu_wdata = 8'h00;
  logic [7:0] cpu_rdata;
  logic       hw_rx_done = 1'b0, hw_rx_busy = 1'b0, hw_bus_sync = 1'b0;
  logic       hw_init_ack = 1'b0, hw_loopback = 1'b0, wait_mode = 1'b0;
  logic       ctl_clk_stop_wait, ctl_timer_en, ctl_wake_en, ctl_sleep_req, ctl_init_req;
  logic       bif_clk_en;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // Behavioural reference state
  bit m_rx, m_busy, m_sync, m_csw, m_tim, m_wake, m_slp, m_init, m_ce;

  always #5 clk = ~clk;

  canctl_reg u0 (
    .clk(clk), .rst(rst), .cpu_wr_en(cpu_wr_en), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .hw_rx_done(hw_rx_done), .hw_rx_busy(hw_rx_busy),
    .hw_bus_sync(hw_bus_sync), .hw_init_ack(hw_init_ack), .hw_loopback(hw_loopback),
    .wait_mode(wait_mode), .ctl_clk_stop_wait(ctl_clk_stop_wait),
    .ctl_timer_en(ctl_timer_en), .ctl_wake_en(ctl_wake_en),
    .ctl_sleep_req(ctl_sleep_req), .ctl_init_req(ctl_init_req),
    .bif_clk_en(bif_clk_en)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] model_view();
    return {m_rx, m_busy, m_csw, m_sync, m_tim, m_wake, m_slp, m_init};
  endfunction

  task automatic model_reset();
    m_rx = 0; m_busy = 0; m_csw = 0; m_sync = 0; m_tim = 0;
    m_wake = 0; m_slp = 0; m_init = 1; m_ce = 1;
  endtask

  // One clock: update the model at the edge, compare at the falling edge.
  task automatic step();
    bit frz, opn, wr;
    @(posedge clk);
    if (rst) model_reset();
    else begin
      frz = m_init && hw_init_ack;
      opn = !m_init && !hw_init_ack;
      wr  = cpu_wr_en;
      m_ce = !(m_csw && wait_mode);
      if (frz) m_rx = 0;
      else if (hw_rx_done && !hw_loopback) m_rx = 1;
      else if (wr && cpu_wdata[7]) m_rx = 0;
      m_busy = frz ? 1'b0 : hw_rx_busy;
      m_sync = frz ? 1'b0 : hw_bus_sync;
      if (frz) begin m_csw = 0; m_tim = 0; end
      else if (wr && opn) begin m_csw = cpu_wdata[5]; m_tim = cpu_wdata[3]; end
      if (wr && opn) begin m_wake = cpu_wdata[2]; m_slp = cpu_wdata[1]; end
      if (wr) m_init = cpu_wdata[0];
    end
    @(negedge clk);
    if (!rst) begin
      chk("R2", cpu_rdata, model_view());
      chk("R11", {3'b0, ctl_clk_stop_wait, ctl_timer_en, ctl_wake_en, ctl_sleep_req, ctl_init_req},
          {3'b0, m_csw, m_tim, m_wake, m_slp, m_init});
      chk("R10", {7'b0, bif_clk_en}, {7'b0, m_ce});
    end
  endtask

  task automatic wr(input logic [7:0] d);
    cpu_wr_en = 1; cpu_wdata = d;
    step();
    cpu_wr_en = 0; cpu_wdata = 8'h00;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    model_reset();
    repeat (3) step();
    rst = 0;
    @(negedge clk);
    // R1: reset state
    chk("R1", cpu_rdata, 8'h01);
    chk("R1", {ctl_clk_stop_wait, ctl_timer_en, ctl_wake_en, ctl_sleep_req, bif_clk_en}, 5'b00001);

    // R9: init_req still 1 (ack 0): only bit 0 writable
    wr(8'h2F);
    chk("R9", cpu_rdata, 8'h01);

    // R8: enter init mode; status pulses are forced away
    hw_init_ack = 1; hw_rx_busy = 1; hw_bus_sync = 1;
    step();
    hw_rx_done = 1; step(); hw_rx_done = 0;
    step();
    chk("R8", {3'b0, cpu_rdata[7:3]}, 8'h00);

    // Drop init request while ack is still 1: still locked
    wr(8'h00);
    wr(8'h0E);
    chk("R9", {5'b0, cpu_rdata[2:0]}, 8'h00);
    hw_init_ack = 0; hw_rx_busy = 0; hw_bus_sync = 0;
    step();

    // Open: write all controls
    wr(8'h2E);
    chk("R9", cpu_rdata, 8'h2E);

    // R10: wait-mode clock gate
    wait_mode = 1; step();
    chk("R10", {7'b0, bif_clk_en}, 8'h00);
    wait_mode = 0; step();
    chk("R10", {7'b0, bif_clk_en}, 8'h01);

    // R3 / R4: sticky flag and write-one-clear
    hw_rx_done = 1; step(); hw_rx_done = 0;
    chk("R3", {7'b0, cpu_rdata[7]}, 8'h01);
    step(); step();
    chk("R3", {7'b0, cpu_rdata[7]}, 8'h01);
    wr(8'h2E);
    chk("R4", {7'b0, cpu_rdata[7]}, 8'h01);
    wr(8'hAE);
    chk("R4", {7'b0, cpu_rdata[7]}, 8'h00);
    wr(8'hAE);
    chk("R4", {7'b0, cpu_rdata[7]}, 8'h00);

    // R5: set wins over simultaneous clear
    hw_rx_done = 1; wr(8'hAE); hw_rx_done = 0;
    chk("R5", {7'b0, cpu_rdata[7]}, 8'h01);
    wr(8'hAE);

    // R6: loopback blocks the pulse
    hw_loopback = 1; hw_rx_done = 1; step(); hw_rx_done = 0; step();
    chk("R6", {7'b0, cpu_rdata[7]}, 8'h00);
    hw_loopback = 0;

    // R7: read-only status bits
    hw_rx_busy = 1; wr(8'h2E);
    chk("R7", {7'b0, cpu_rdata[6]}, 8'h01);
    hw_rx_busy = 0; hw_bus_sync = 1; wr(8'h7E);
    chk("R7", {6'b0, cpu_rdata[6], cpu_rdata[4]}, 8'h01);
    hw_bus_sync = 0; step();
    chk("R7", {6'b0, cpu_rdata[6], cpu_rdata[4]}, 8'h00);

    // R8: re-enter init; csw/timer forced, wake/sleep kept
    wr(8'h2F);
    hw_init_ack = 1; step(); step();
    chk("R8", cpu_rdata, 8'h07);
    wr(8'h00); hw_init_ack = 0; step();

    // Pseudo-random phase, compared on every clock against the model
    lfsr = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      hw_rx_done  = lfsr[0] & lfsr[3];
      hw_rx_busy  = lfsr[1];
      hw_bus_sync = lfsr[2];
      hw_loopback = lfsr[4] & lfsr[5] & lfsr[6];
      if (lfsr[7] & lfsr[8]) hw_init_ack = ~hw_init_ack;
      wait_mode   = lfsr[9];
      cpu_wr_en   = lfsr[10] & lfsr[11];
      cpu_wdata   = {lfsr[15:12], lfsr[3:0]};
      step();
    end
    cpu_wr_en = 0;

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule